// File: doc/BRIEF.md
# Keyed Write-Protection Sequencer

This block sits between a bus-side write port and the page-write engine of a byte-wide non-volatile memory. It sees every byte write as a single-cycle strobe with an address and a data byte. For each strobe it makes two same-cycle decisions. The first is whether the write may reach the array (`pass_o`). The second is whether the write was consumed as a step of a command key (`cmd_o`). Command bytes are never forwarded to the array.

A three-write key turns protection on. A six-write key turns it off. Both keys use the two fixed addresses 1555h and 0AAAh, and each key write must follow the previous one within a page-load window of `WIN_CYC` clock cycles. While protection is on, ordinary writes are dropped. The exception is a page of data that directly follows the three-write arming key: that page is forwarded, and protection stays on. An external restore strobe loads the protection flag, which lets an outer model carry the flag across power cycles.

The controller has seven states:
- `ST_IDLE`: waiting for the lead step.
- `ST_UNLK1`: the lead step has been seen.
- `ST_UNLK2`: the second step has been seen.
- `ST_OFF3`, `ST_OFF4`, `ST_OFF5`: the disarm path.
- `ST_OPEN`: the keyed page window is open.

Its transitions are:
- `ST_IDLE -> ST_UNLK1`: lead step.
- `ST_UNLK1 -> ST_UNLK2`: second step.
- `ST_UNLK2 -> ST_OPEN`: arm step, which sets protection.
- `ST_UNLK2 -> ST_OFF3`: prepare step.
- `ST_OFF3 -> ST_OFF4`: lead step.
- `ST_OFF4 -> ST_OFF5`: second step.
- `ST_OFF5 -> ST_IDLE`: disarm step, which clears protection.
- Any non-idle state `-> ST_IDLE`: a wrong step, expiry of the window, or a restore strobe.

Top module: `keyseq_guard`

## Requirements
- R1: After reset the protection flag (`prot_o`) is 0, the keyed window (`keyed_o`) is closed, and the sequencer is idle.
- R2: Three consecutive writes, AAh to 1555h, then 55h to 0AAAh, then A0h to 1555h, set `prot_o` to 1 and open the keyed window. Each of the three has `cmd_o`=1 and `pass_o`=0.
- R3: Six consecutive writes clear `prot_o` to 0. The writes are AAh to 1555h, 55h to 0AAAh, 80h to 1555h, AAh to 1555h, 55h to 0AAAh, then 20h to 1555h. Each of the six has `cmd_o`=1 and `pass_o`=0.
- R4: With `prot_o`=1 and the keyed window closed, a write that is not a command step gives `pass_o`=0 and `cmd_o`=0.
- R5: With `prot_o`=0, a write that is not a command step gives `pass_o`=1 and `cmd_o`=0.
- R6: While the keyed window is open, every write gives `pass_o`=1 and `cmd_o`=0, and `prot_o` stays 1.
- R7: The keyed window closes when `WIN_CYC` clock edges pass after the last write with no new strobe. A write on the `WIN_CYC`-th edge still passes and restarts the window.
- R8: A write that does not match the expected next step returns the sequencer to idle. That write is handled as an ordinary write (R4/R5), and the key must then restart from its first step.
- R9: Command steps separated by at most `WIN_CYC` edges continue the key. A gap longer than that aborts it, and the late step is handled as an ordinary write.
- R10: A cycle with `restore_vld`=1 loads `prot_o` from `restore_val`, closes the keyed window and aborts any partial key. It takes priority over a strobe in the same cycle.
- R11: With `wr_stb`=0, both `pass_o` and `cmd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| restore_vld | input | 1 | Load strobe for the protection flag |
| restore_val | input | 1 | Value loaded on `restore_vld` |
| pass_o | output | 1 | Write may reach the page-write engine (same cycle) |
| cmd_o | output | 1 | Write was consumed as a key step (same cycle) |
| prot_o | output | 1 | Current protection flag |
| keyed_o | output | 1 | Keyed page window is open |

## Verification
The hardest situations to reach are the timing edges of the page-load window. A key step or page write must land exactly on the last allowed edge, and another exactly one edge later. The bench counts idle cycles between strobes in dedicated tasks: `WIN_CYC-1` idle cycles must keep the key alive, and `WIN_CYC` idle cycles must abort it. It applies this both inside a partial key and after the keyed page. A restore strobe is also injected in the middle of a partial key, and the bench then shows that the completing step is treated as plain data.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_UNLK1 = 3'd1,
        ST_UNLK2 = 3'd2,
        ST_OFF3  = 3'd3,
        ST_OFF4  = 3'd4,
        ST_OFF5  = 3'd5,
        ST_OPEN  = 3'd6
    } seq_state_e;

    // key step indices
    localparam int KEY_N      = 5;
    localparam int K_LEAD     = 0;  // AAh @ 1555h
    localparam int K_SECOND   = 1;  // 55h @ 0AAAh
    localparam int K_ARM      = 2;  // A0h @ 1555h
    localparam int K_PREP     = 3;  // 80h @ 1555h
    localparam int K_DISARM   = 4;  // 20h @ 1555h

    localparam logic [15:0] ADDR_HI_KEY = 16'h1555;
    localparam logic [15:0] ADDR_LO_KEY = 16'h0AAA;

    function automatic logic [15:0] key_addr(input int k);
        return (k == K_SECOND) ? ADDR_LO_KEY : ADDR_HI_KEY;
    endfunction

    function automatic logic [7:0] key_data(input int k);
        logic [7:0] d;
        case (k)
            K_LEAD:   d = 8'hAA;
            K_SECOND: d = 8'h55;
            K_ARM:    d = 8'hA0;
            K_PREP:   d = 8'h80;
            default:  d = 8'h20;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/keyseq_decode.sv
module keyseq_decode
    import keyseq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [KEY_N-1:0]  hit
);

    for (genvar k = 0; k < KEY_N; k++) begin : g_key
        localparam logic [ADDR_W-1:0] KA = ADDR_W'(key_addr(k));
        localparam logic [DATA_W-1:0] KD = DATA_W'(key_data(k));
        assign hit[k] = (addr == KA) && (data == KD);
    end

endmodule

// File: rtl/keyseq_window.sv
module keyseq_window #(
    parameter int WIN_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stb,
    output logic expire
);

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYC - 1);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (stb || !run) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // fires on the WIN_CYC-th strobe-free edge after the last strobe
    assign expire = run && !stb && (idle_cnt == CNT_LAST);

endmodule

// File: rtl/keyseq_fsm.sv
module keyseq_fsm
    import keyseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [KEY_N-1:0] hit,
    input  logic             expire,
    input  logic             restore_vld,
    input  logic             restore_val,
    output seq_state_e       state,
    output logic             prot,
    output logic             pass,
    output logic             cmd
);

    seq_state_e nxt;
    logic       prot_nxt;
    logic       step_ok;

    always_comb begin
        nxt      = state;
        prot_nxt = prot;
        step_ok  = 1'b0;
        if (stb) begin
            unique case (state)
                ST_IDLE: begin
                    if (hit[K_LEAD]) begin
                        nxt = ST_UNLK1; step_ok = 1'b1;
                    end
                end
                ST_UNLK1: begin
                    if (hit[K_SECOND]) begin
                        nxt = ST_UNLK2; step_ok = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_UNLK2: begin
                    if (hit[K_ARM]) begin
                        nxt = ST_OPEN; prot_nxt = 1'b1; step_ok = 1'b1;
                    end else if (hit[K_PREP]) begin
                        nxt = ST_OFF3; step_ok = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_OFF3: begin
                    if (hit[K_LEAD]) begin
                        nxt = ST_OFF4; step_ok = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_OFF4: begin
                    if (hit[K_SECOND]) begin
                        nxt = ST_OFF5; step_ok = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_OFF5: begin
                    if (hit[K_DISARM]) begin
                        nxt = ST_IDLE; prot_nxt = 1'b0; step_ok = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_OPEN: nxt = ST_OPEN;
                default: nxt = ST_IDLE;
            endcase
        end else if (expire) begin
            nxt = ST_IDLE;
        end
        if (restore_vld) begin
            nxt      = ST_IDLE;
            prot_nxt = restore_val;
            step_ok  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            prot  <= 1'b0;
        end else begin
            state <= nxt;
            prot  <= prot_nxt;
        end
    end

    always_comb begin
        cmd  = stb && step_ok;
        pass = stb && !step_ok && !restore_vld && ((state == ST_OPEN) || !prot);
    end

endmodule

// File: rtl/keyseq_guard.sv
module keyseq_guard
    import keyseq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int WIN_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              restore_vld,
    input  logic              restore_val,
    output logic              pass_o,
    output logic              cmd_o,
    output logic              prot_o,
    output logic              keyed_o
);

    logic [KEY_N-1:0] key_hit;
    logic             win_expire;
    seq_state_e       seq_state;

    keyseq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (key_hit)
    );

    keyseq_window #(.WIN_CYC(WIN_CYC)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (seq_state != ST_IDLE),
        .stb    (wr_stb),
        .expire (win_expire)
    );

    keyseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (wr_stb),
        .hit         (key_hit),
        .expire      (win_expire),
        .restore_vld (restore_vld),
        .restore_val (restore_val),
        .state       (seq_state),
        .prot        (prot_o),
        .pass        (pass_o),
        .cmd         (cmd_o)
    );

    assign keyed_o = (seq_state == ST_OPEN);

endmodule

// File: rtl/keyseq_guard_chk.sv
module keyseq_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic restore_vld,
    input logic restore_val,
    input logic pass_o,
    input logic cmd_o,
    input logic prot_o,
    input logic keyed_o
);

    a_r11_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> (!pass_o && !cmd_o));

    a_r2_cmd_never_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o |-> !pass_o);

    a_r4_locked_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && prot_o && !keyed_o && !cmd_o) |-> !pass_o);

    a_r5_open_forwards_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !prot_o && !cmd_o && !restore_vld) |-> pass_o);

    a_r6_window_needs_prot: assert property (@(posedge clk) disable iff (!rst_n)
        keyed_o |-> prot_o);

    a_r2_window_opens_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(keyed_o) |-> ($past(cmd_o) && prot_o));

    a_r1_prot_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_o) |-> $past(cmd_o || restore_vld));

    a_r10_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        restore_vld |=> ((prot_o == $past(restore_val)) && !keyed_o));

endmodule

bind keyseq_guard keyseq_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .restore_vld (restore_vld),
    .restore_val (restore_val),
    .pass_o      (pass_o),
    .cmd_o       (cmd_o),
    .prot_o      (prot_o),
    .keyed_o     (keyed_o)
);

// File: tb/keyseq_guard_tb.sv
module keyseq_guard_tb;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int WIN    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              restore_vld = 1'b0;
    logic              restore_val = 1'b0;
    logic              pass_o, cmd_o, prot_o, keyed_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    keyseq_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_CYC(WIN)) u_dut (
        .clk, .rst_n, .wr_stb, .wr_addr, .wr_data,
        .restore_vld, .restore_val,
        .pass_o, .cmd_o, .prot_o, .keyed_o
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // one-cycle write from a negedge; checks same-cycle decision
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input int exp_pass, input int exp_cmd, input string tag);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk(int'(pass_o), exp_pass, {tag, " pass"});
        chk(int'(cmd_o),  exp_cmd,  {tag, " cmd"});
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_key(input string tag);
        wr(13'h1555, 8'hAA, 0, 1, tag);
        wr(13'h0AAA, 8'h55, 0, 1, tag);
        wr(13'h1555, 8'hA0, 0, 1, tag);
    endtask

    task automatic t_reset();
        chk(int'(prot_o),  0, "R1 prot after reset");
        chk(int'(keyed_o), 0, "R1 keyed after reset");
        chk(int'(pass_o),  0, "R11 pass idle");
        chk(int'(cmd_o),   0, "R11 cmd idle");
    endtask

    task automatic t_unprotected();
        wr(13'h0100, 8'h12, 1, 0, "R5 plain write");
        wr(13'h1FFF, 8'h00, 1, 0, "R5 plain write top");
    endtask

    task automatic t_arm_and_page();
        arm_key("R2 arm step");
        chk(int'(prot_o),  1, "R2 prot set");
        chk(int'(keyed_o), 1, "R2 window open");
        wr(13'h0200, 8'h01, 1, 0, "R6 page byte");
        wr(13'h0201, 8'h02, 1, 0, "R6 page byte");
        wr(13'h1555, 8'hAA, 1, 0, "R6 page byte key-like");
        chk(int'(prot_o), 1, "R6 prot kept");
    endtask

    task automatic t_window_end();
        idle(WIN - 1);
        chk(int'(keyed_o), 1, "R7 window at last edge");
        wr(13'h0203, 8'h03, 1, 0, "R7 write on last edge");
        idle(WIN);
        chk(int'(keyed_o), 0, "R7 window closed");
        wr(13'h0204, 8'h04, 0, 0, "R4 locked write");
        chk(int'(prot_o), 1, "R4 prot held");
    endtask

    task automatic t_mismatch();
        wr(13'h1555, 8'hAA, 0, 1, "R8 lead step");
        wr(13'h0AAA, 8'h33, 0, 0, "R8 wrong data");
        wr(13'h0AAA, 8'h55, 0, 0, "R8 no resume");
        chk(int'(keyed_o), 0, "R8 stays closed");
    endtask

    task automatic t_gap();
        wr(13'h1555, 8'hAA, 0, 1, "R9 lead step");
        idle(WIN);
        wr(13'h0AAA, 8'h55, 0, 0, "R9 late step");
        wr(13'h1555, 8'hAA, 0, 1, "R9 lead again");
        idle(WIN - 1);
        wr(13'h0AAA, 8'h55, 0, 1, "R9 step on last edge");
        wr(13'h1555, 8'hA0, 0, 1, "R9 arm step");
        chk(int'(keyed_o), 1, "R9 key completed");
        idle(WIN);
        chk(int'(keyed_o), 0, "R7 window closed again");
    endtask

    task automatic t_disarm();
        wr(13'h1555, 8'hAA, 0, 1, "R3 step1");
        wr(13'h0AAA, 8'h55, 0, 1, "R3 step2");
        wr(13'h1555, 8'h80, 0, 1, "R3 step3");
        chk(int'(prot_o), 1, "R3 prot mid key");
        wr(13'h1555, 8'hAA, 0, 1, "R3 step4");
        wr(13'h0AAA, 8'h55, 0, 1, "R3 step5");
        wr(13'h1555, 8'h20, 0, 1, "R3 step6");
        chk(int'(prot_o), 0, "R3 prot cleared");
        wr(13'h0400, 8'h5A, 1, 0, "R5 write after disarm");
        wr(13'h1555, 8'hAA, 0, 1, "R8 lead unprotected");
        wr(13'h0300, 8'h77, 1, 0, "R8 mismatch passes");
    endtask

    task automatic t_restore();
        restore_vld = 1'b1; restore_val = 1'b1;
        @(negedge clk);
        restore_vld = 1'b0;
        chk(int'(prot_o), 1, "R10 restore set");
        wr(13'h0500, 8'h11, 0, 0, "R10 restored lock");
        restore_vld = 1'b1; restore_val = 1'b0;
        @(negedge clk);
        restore_vld = 1'b0;
        chk(int'(prot_o), 0, "R10 restore clear");
        wr(13'h1555, 8'hAA, 0, 1, "R10 lead step");
        wr(13'h0AAA, 8'h55, 0, 1, "R10 second step");
        restore_vld = 1'b1; restore_val = 1'b0;
        @(negedge clk);
        restore_vld = 1'b0;
        wr(13'h1555, 8'hA0, 1, 0, "R10 key aborted");
        chk(int'(prot_o),  0, "R10 prot unchanged");
        chk(int'(keyed_o), 0, "R10 window closed");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unprotected();
        t_arm_and_page();
        t_window_end();
        t_mismatch();
        t_gap();
        t_disarm();
        t_restore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule